// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address of the next microinstruction for a microprogrammed control unit with a 128-word control store. It keeps the current control address in a register and also keeps a single-entry return register. On every clock edge it loads the control address from one of four sources: the current address plus one, the jump target carried by the current microinstruction, the saved return address, or an entry address derived from the machine opcode.

The current microinstruction supplies two fields. The branch-kind field selects jump, call, return or opcode dispatch. The condition-select field chooses which status flag is tested: always true, the indirect bit, the accumulator sign, or the accumulator-zero flag. A jump or call is taken only when the tested flag is 1. Otherwise the sequencer continues in line. A taken call saves the address after the call, so that a later return resumes the program just past the call. Opcode dispatch places each machine instruction's routine at a multiple of four in the lower half of the store. Reset starts execution at address 64, where the fetch routine sits.

Top module: `useq_nextaddr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ctl_addr` becomes 64 and the return register is cleared to 0, so a return issued right after reset goes to address 0.
- R2: `cond_sel` chooses the test bit: 0 gives a constant 1, 1 gives `ind_bit`, 2 gives `ac_sign` and 3 gives `ac_zero`.
- R3: With `br_kind` = 00 (jump) and a test bit of 1, the next `ctl_addr` equals `br_target`.
- R4: With `br_kind` = 00 (jump) or 01 (call) and a test bit of 0, the next `ctl_addr` is the current one plus 1, modulo 128, so 127 is followed by 0.
- R5: With `br_kind` = 01 (call) and a test bit of 1, the next `ctl_addr` equals `br_target` and the return register takes the current `ctl_addr` plus 1, modulo 128.
- R6: `ret_load` is high in the same cycle exactly when `br_kind` = 01 and the test bit is 1. It is low for every other combination.
- R7: With `br_kind` = 10 (return), the next `ctl_addr` is the return register's content, whatever the test bit is.
- R8: With `br_kind` = 11 (dispatch), the next `ctl_addr` is {0, opcode[3:0], 00}, that is opcode times 4, whatever the test bit is.
- R9: The return register keeps its value through every cycle that is not a taken call. A second taken call overwrites it, because there is only one level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_sel | input | 2 | Condition-select field of the current microinstruction |
| br_kind | input | 2 | Branch-kind field: 00 jump, 01 call, 10 return, 11 dispatch |
| br_target | input | 7 | Target-address field of the current microinstruction |
| ind_bit | input | 1 | Indirect bit of the current machine instruction |
| ac_sign | input | 1 | Accumulator sign flag |
| ac_zero | input | 1 | Accumulator-zero flag |
| opcode | input | 4 | Opcode of the current machine instruction |
| ctl_addr | output | 7 | Registered control-store address |
| ret_load | output | 1 | Strobe for a taken call; the return register loads on this edge |

## Verification
The assertions assume that every input field is a known value at each rising edge while reset is released. They also assume that the flags have settled before the edge, because the test bit feeds the next-address choice combinationally. The stimulus changes all inputs only on the falling edge and always drives every field with a defined value, including fields that the selected branch kind ignores. Those ignored fields are set deliberately to values that would alter the result if they were wrongly used.

// File: rtl/useq_pkg.sv
// Package: shared widths and field encodings for the next-address sequencer.
// Assumes a 128-word control store and a 4-bit opcode.
package useq_pkg;
    localparam int ADDR_W    = 7;
    localparam int OPC_W     = 4;
    localparam int MAP_SHIFT = 2;
    localparam int N_COND    = 4;

    // Branch-kind field encoding (bit 1 = I1, bit 0 = I0)
    typedef enum logic [1:0] {
        BR_JMP  = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_kind_e;

    // Next-address source select
    typedef enum logic [1:0] {
        SRC_INC = 2'b00,
        SRC_TGT = 2'b01,
        SRC_RET = 2'b10,
        SRC_MAP = 2'b11
    } src_e;
endpackage

// File: rtl/useq_cond_mux.sv
// Module: useq_cond_mux
// Picks one status flag as the branch test bit.
// Assumes flag index 0 is tied to a constant 1 by the parent.
module useq_cond_mux #(
    parameter int N_COND = 4,
    localparam int SEL_W = (N_COND > 1) ? $clog2(N_COND) : 1
) (
    input  logic [N_COND-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              test
);
    // Index the flag vector by the condition-select field
    always_comb begin
        test = flags[sel];
    end
endmodule

// File: rtl/useq_select_logic.sv
// Module: useq_select_logic
// Turns the branch kind and the test bit into a source select and a return-load strobe.
// Assumes the encodings in useq_pkg.
module useq_select_logic
    import useq_pkg::*;
(
    input  logic [1:0] br_kind,
    input  logic       test,
    output src_e       src,
    output logic       ret_load
);
    logic i1, i0;
    logic s1, s0;

    // Split the branch-kind field into its two control bits
    always_comb begin
        i1 = br_kind[1];
        i0 = br_kind[0];
    end

    // Boolean select equations: S1 follows I1; S0 is I0 for return/dispatch and T for jump/call
    always_comb begin
        s1       = i1;
        s0       = (i1 & i0) | (~i1 & test);
        src      = src_e'({s1, s0});
        ret_load = ~i1 & i0 & test;
    end
endmodule

// File: rtl/useq_opmap.sv
// Module: useq_opmap
// Forms the routine entry address from the opcode: a zero top field, the opcode, then MAP_SHIFT zeros.
// Assumes ADDR_W > OPC_W + MAP_SHIFT.
module useq_opmap #(
    parameter int ADDR_W    = 7,
    parameter int OPC_W     = 4,
    parameter int MAP_SHIFT = 2,
    localparam int PAD_W    = ADDR_W - OPC_W - MAP_SHIFT
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] map_addr
);
    // Place the opcode between the zero pad and the zero low bits
    always_comb begin
        map_addr = {{PAD_W{1'b0}}, opcode, {MAP_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/useq_nextaddr.sv
// Module: useq_nextaddr
// Top of the next-address sequencer. Holds the control address and a
// one-level return register and chooses the next address from four sources.
// Assumes that all inputs are stable before each rising edge; reset is synchronous and active low.
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int ADDR_W     = useq_pkg::ADDR_W,
    parameter int OPC_W      = useq_pkg::OPC_W,
    parameter int MAP_SHIFT  = useq_pkg::MAP_SHIFT,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              ind_bit,
    input  logic              ac_sign,
    input  logic              ac_zero,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic              ret_load
);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] START     = ADDR_W'(RESET_ADDR);
    localparam logic [ADDR_W-1:0] MAP_LOMSK = ADDR_W'((1 << MAP_SHIFT) - 1);

    logic [N_COND-1:0] flags;
    logic              test_bit;
    src_e              src;
    logic [ADDR_W-1:0] inc_addr;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] next_addr;

    // Gather the status flags in condition-select order
    always_comb begin
        flags = {ac_zero, ac_sign, ind_bit, 1'b1};
    end

    useq_cond_mux #(.N_COND(N_COND)) u_cond (
        .flags (flags),
        .sel   (cond_sel),
        .test  (test_bit)
    );

    useq_select_logic u_sel (
        .br_kind  (br_kind),
        .test     (test_bit),
        .src      (src),
        .ret_load (ret_load)
    );

    useq_opmap #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_SHIFT(MAP_SHIFT)) u_map (
        .opcode   (opcode),
        .map_addr (map_addr)
    );

    // Incrementer, wrapping modulo the store size
    always_comb begin
        inc_addr = ctl_addr + ONE;
    end

    // Four-way next-address multiplexer
    always_comb begin
        unique case (src)
            SRC_INC: next_addr = inc_addr;
            SRC_TGT: next_addr = br_target;
            SRC_RET: next_addr = ret_q;
            SRC_MAP: next_addr = map_addr;
            default: next_addr = inc_addr;
        endcase
    end

    // Control address register
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_addr <= START;
        else        ctl_addr <= next_addr;
    end

    // Return register: captures the address after a taken call
    always_ff @(posedge clk) begin
        if (!rst_n)        ret_q <= '0;
        else if (ret_load) ret_q <= inc_addr;
    end

    // R3
    jmp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == BR_JMP && test_bit) |=> ctl_addr == $past(br_target));

    // R4
    not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_kind[1] && !test_bit) |=> ctl_addr == $past(ctl_addr) + ONE);

    // R5
    call_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_load |=> (ret_q == $past(ctl_addr) + ONE) && (ctl_addr == $past(br_target)));

    // R6
    strobe_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_load |-> (br_kind == BR_CALL));

    // R7
    ret_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == BR_RET) |=> ctl_addr == $past(ret_q));

    // R8
    map_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == BR_MAP) |=> ((ctl_addr & MAP_LOMSK) == '0) && !ctl_addr[ADDR_W-1]);

    // R9
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_load |=> $stable(ret_q));
endmodule

// File: tb/sim_useq_nextaddr.sv
// Scoreboard bench for useq_nextaddr.
module sim_useq_nextaddr;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_kind = '0;
    logic [6:0] br_target = '0;
    logic       ind_bit = 1'b0;
    logic       ac_sign = 1'b0;
    logic       ac_zero = 1'b0;
    logic [3:0] opcode = '0;
    logic [6:0] ctl_addr;
    logic       ret_load;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [6:0] exp_q[$];
    string      tag_q[$];

    logic [6:0] m_addr = 7'd0;
    logic [6:0] m_ret  = 7'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_nextaddr u0 (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_kind(br_kind),
        .br_target(br_target), .ind_bit(ind_bit), .ac_sign(ac_sign),
        .ac_zero(ac_zero), .opcode(opcode), .ctl_addr(ctl_addr), .ret_load(ret_load)
    );

    // Monitor: after each rising edge, pop one expectation and compare it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (ctl_addr !== e) begin
                    n_bad++;
                    $display("FAIL %s: ctl_addr actual %0d expected %0d", t, ctl_addr, e);
                end
            end
        end
    end

    // Reset step: expects the start address and a cleared return register (R1)
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        m_addr = 7'd64;
        m_ret  = 7'd0;
        exp_q.push_back(m_addr);
        tag_q.push_back(tag);
    endtask

    // Driver: apply one microinstruction, check the strobe, push the expected address
    task automatic step(input logic [1:0] kind, input logic [1:0] cs, input logic [6:0] tgt,
                        input logic [3:0] opc, input logic i, input logic s, input logic z,
                        input string tag);
        logic t;
        logic exp_ld;
        logic [6:0] nxt;
        @(negedge clk);
        rst_n = 1'b1;
        br_kind = kind; cond_sel = cs; br_target = tgt; opcode = opc;
        ind_bit = i; ac_sign = s; ac_zero = z;
        case (cs)
            2'd0: t = 1'b1;
            2'd1: t = i;
            2'd2: t = s;
            default: t = z;
        endcase
        exp_ld = (kind == 2'b01) && t;
        #1;
        n_cmp++;
        if (ret_load !== exp_ld) begin
            n_bad++;
            $display("FAIL R6 (%s): ret_load actual %0b expected %0b", tag, ret_load, exp_ld);
        end
        case (kind)
            2'b00: nxt = t ? tgt : m_addr + 7'd1;
            2'b01: nxt = t ? tgt : m_addr + 7'd1;
            2'b10: nxt = m_ret;
            default: nxt = {1'b0, opc, 2'b00};
        endcase
        if (exp_ld) m_ret = m_addr + 7'd1;
        m_addr = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset");
        do_reset("R1 reset hold");
        step(2'b10, 2'd2, 7'd99, 4'hF, 1, 0, 1, "R1 return after reset -> 0 (R7)");
        do_reset("R1 reset again");
        step(2'b00, 2'd0, 7'd10, 4'h3, 0, 0, 0, "R3 R2 jump always");
        step(2'b00, 2'd1, 7'd90, 4'h3, 0, 1, 1, "R4 R2 jump on ind=0");
        step(2'b00, 2'd1, 7'd20, 4'h3, 1, 0, 0, "R3 R2 jump on ind=1");
        step(2'b00, 2'd2, 7'd30, 4'h3, 0, 1, 0, "R3 R2 jump on sign=1");
        step(2'b00, 2'd2, 7'd77, 4'h3, 1, 0, 1, "R4 R2 jump on sign=0");
        step(2'b00, 2'd3, 7'd5,  4'h3, 0, 0, 1, "R3 R2 jump on zero=1");
        step(2'b00, 2'd3, 7'd88, 4'h3, 1, 1, 0, "R4 R2 jump on zero=0");
        step(2'b01, 2'd0, 7'd100, 4'h0, 0, 0, 0, "R5 call taken");
        step(2'b00, 2'd3, 7'd44, 4'h0, 1, 1, 0, "R9 untaken jump");
        step(2'b01, 2'd1, 7'd55, 4'h0, 0, 1, 1, "R4 R9 untaken call");
        step(2'b10, 2'd2, 7'd33, 4'h9, 1, 0, 1, "R7 return");
        step(2'b11, 2'd3, 7'd12, 4'hA, 1, 1, 0, "R8 dispatch A");
        step(2'b11, 2'd1, 7'd12, 4'hF, 0, 0, 0, "R8 dispatch F");
        step(2'b11, 2'd0, 7'd99, 4'h0, 1, 1, 1, "R8 dispatch 0");
        step(2'b00, 2'd0, 7'd127, 4'h0, 0, 0, 0, "R3 jump to top");
        step(2'b00, 2'd1, 7'd50, 4'h0, 0, 0, 0, "R4 wrap 127->0");
        step(2'b00, 2'd0, 7'd127, 4'h0, 0, 0, 0, "R3 jump to top");
        step(2'b01, 2'd2, 7'd3, 4'h0, 0, 1, 0, "R5 call from top");
        step(2'b10, 2'd0, 7'd70, 4'h0, 0, 0, 0, "R5 R7 return wraps to 0");
        step(2'b01, 2'd0, 7'd50, 4'h0, 0, 0, 0, "R5 first call");
        step(2'b01, 2'd3, 7'd60, 4'h0, 0, 0, 1, "R9 second call overwrites");
        step(2'b10, 2'd1, 7'd0, 4'h0, 0, 0, 0, "R9 return to 51");
        step(2'b10, 2'd3, 7'd0, 4'h0, 1, 1, 1, "R9 return again to 51");
        step(2'b11, 2'd0, 7'd0, 4'h5, 0, 0, 0, "R8 dispatch 5");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule